// File: doc/BRIEF.md
# Timer Compare Output Waveform Generator

This block holds an up-counting timer and two compare channels, A and B. Each channel turns counter matches into a level on its own output pin. A 4-bit waveform code chooses how the counter runs and which family of actions applies. A 2-bit output mode per channel then picks the action for that channel. In the non-PWM families, a match can toggle, clear or set the channel. In fast PWM, the channel is set at one end of the period and cleared at the other, which gives a duty cycle that follows the compare value.

A channel's waveform reaches its pin only when the channel is connected and its direction enable is high. A drive flag per channel reports this. The channel's state register keeps running while the pin is not driven.

Top module: `cmp_wavegen`

## Requirements
- R1: A synchronous active-low reset clears the counter and both channel state registers. Pins read 0 while reset is held and right after it is released.
- R2: Waveform code 0 is Normal counting, which wraps from 2^CNT_W-1 to 0. Codes 4 and 12 are CTC. Codes 5, 6, 7, 14 and 15 are fast PWM. Every other code behaves as Normal.
- R3: In CTC and fast PWM the counter wraps from the `top_val` input to 0, so one period lasts `top_val`+1 cycles.
- R4: In Normal and CTC, output mode 01 toggles the channel when the counter equals its compare value. The pin changes on the clock edge that ends the matching cycle.
- R5: In Normal and CTC, output mode 10 clears the channel on a match and output mode 11 sets it.
- R6: Output mode 00 disconnects the channel in every waveform family, so the drive flag and the pin are 0.
- R7: In fast PWM, output mode 10 sets the channel when the counter is at top and clears it on a match. With compare value C < top T, the pin is high for C+1 of every T+1 cycles. With C > T it is high for the whole period.
- R8: In fast PWM, output mode 11 is the inverse of R7. The pin is high for T-C of every T+1 cycles when C < T, and for 0 cycles when C > T.
- R9: In fast PWM with output mode 10 or 11 and compare value equal to top, the match is ignored and only the action at top applies. The pin stays constantly high (mode 10) or constantly low (mode 11).
- R10: In fast PWM, output mode 01 makes channel A toggle on its match only under codes 14 and 15, and leaves it disconnected under other codes. Channel B is always disconnected under output mode 01.
- R11: With the direction enable low, the drive flag and pin are 0 but the channel state keeps evolving. Raising the enable shows the current state at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wave_mode | input | 4 | Waveform code (R2) |
| top_val | input | CNT_W | Counter top for CTC and fast PWM |
| out_mode_a | input | 2 | Output mode, channel A |
| out_mode_b | input | 2 | Output mode, channel B |
| cmp_a | input | CNT_W | Compare value, channel A |
| cmp_b | input | CNT_W | Compare value, channel B |
| dir_en_a | input | 1 | Direction enable, channel A |
| dir_en_b | input | 1 | Direction enable, channel B |
| pin_a | output | 1 | Pin level, channel A (0 when not driven) |
| pin_b | output | 1 | Pin level, channel B (0 when not driven) |
| drv_a | output | 1 | Channel A pin is driven by the waveform |
| drv_b | output | 1 | Channel B pin is driven by the waveform |

## Verification
The bench builds the block with CNT_W = 8. This brings the Normal-mode overflow within a 256-cycle wrap, so a toggle can be counted over two full wraps. The fast PWM duty cycle is swept over every compare value from 0 to one past top, for tops of 3, 7 and 12, under both codes 5 and 14, with channel A and channel B swapping output modes 10 and 11. The expected high-cycle counts come from the arithmetic in R7 to R9. CTC toggle, set and clear are checked both for exact edge timing and for the number of transitions per period.

// File: rtl/cwg_pkg.sv
// Package: shared types for the compare waveform generator.
// Assumes: the waveform code is 4 bits wide; classification follows R2.
package cwg_pkg;

    typedef enum logic [1:0] {
        WF_NORMAL = 2'd0,
        WF_CTC    = 2'd1,
        WF_FAST   = 2'd2
    } wf_kind_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_TOGGLE = 2'd1,
        ACT_CLEAR  = 2'd2,
        ACT_SET    = 2'd3
    } out_act_e;

    // Map a waveform code to its counting family.
    function automatic wf_kind_e classify_wave(input logic [3:0] code);
        case (code)
            4'd4, 4'd12:                    classify_wave = WF_CTC;
            4'd5, 4'd6, 4'd7, 4'd14, 4'd15: classify_wave = WF_FAST;
            default:                        classify_wave = WF_NORMAL;
        endcase
    endfunction

    // Apply an action to a one-bit channel state.
    function automatic logic apply_act(input out_act_e act, input logic cur);
        case (act)
            ACT_TOGGLE: apply_act = ~cur;
            ACT_CLEAR:  apply_act = 1'b0;
            ACT_SET:    apply_act = 1'b1;
            default:    apply_act = cur;
        endcase
    endfunction

endpackage

// File: rtl/cwg_counter.sv
// Module: cwg_counter
// The free-running up counter. In the Normal family it wraps on natural
// overflow. In CTC and fast PWM it returns to 0 on the cycle after it
// equals the top value, and it flags that top cycle to the channels.
// Assumes: top_i is held steady while counting; a counter already above
// top runs on to the overflow before it obeys top.
module cwg_counter
    import cwg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wf_kind_e         kind_i,
    input  logic [CNT_W-1:0] top_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             at_top_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic             at_top;

    // Top is only meaningful outside the Normal family.
    always_comb begin
        at_top = (kind_i != WF_NORMAL) && (cnt_q == top_i);
    end

    // Count up by one per clock, returning to zero after top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (at_top) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

    assign cnt_o    = cnt_q;
    assign at_top_o = at_top;

    // R3
    top_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i != WF_NORMAL && cnt_q == top_i) |=> (cnt_q == '0));

    // R2
    normal_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == WF_NORMAL && cnt_q == CNT_MAX) |=> (cnt_q == '0));

endmodule

// File: rtl/cwg_channel.sv
// Module: cwg_channel
// One compare channel. It decodes the output mode against the waveform
// family into a match action, a top action and a connected flag, and it
// holds the channel state register. The pin shows the state only when the
// channel is connected and its direction enable is high.
// Assumes: IS_CHAN_A selects the channel that may toggle in fast PWM
// under codes 14 and 15; the match is detected in the cycle where the count
// equals the compare value, and the state changes on the next edge.
module cwg_channel
    import cwg_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter bit IS_CHAN_A = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wf_kind_e         kind_i,
    input  logic [3:0]       wave_code_i,
    input  logic [1:0]       out_mode_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic [CNT_W-1:0] top_i,
    input  logic             at_top_i,
    input  logic             dir_en_i,
    output logic             pin_o,
    output logic             drv_o
);
    logic     match;
    logic     cmp_is_top;
    logic     toggle_code;
    logic     connected;
    out_act_e act_match;
    out_act_e act_top;
    logic     wave_q;
    logic     wave_d;

    // Raw comparisons used by the decode and the next-state logic.
    always_comb begin
        match       = (cnt_i == cmp_i);
        cmp_is_top  = (cmp_i == top_i);
        toggle_code = IS_CHAN_A && ((wave_code_i == 4'd14) || (wave_code_i == 4'd15));
    end

    // Decode output mode and waveform family into actions.
    always_comb begin
        connected = 1'b0;
        act_match = ACT_NONE;
        act_top   = ACT_NONE;
        if (kind_i == WF_FAST) begin
            case (out_mode_i)
                2'b01: begin
                    if (toggle_code) begin
                        connected = 1'b1;
                        act_match = ACT_TOGGLE;
                    end
                end
                2'b10: begin
                    connected = 1'b1;
                    act_match = cmp_is_top ? ACT_NONE : ACT_CLEAR;
                    act_top   = ACT_SET;
                end
                2'b11: begin
                    connected = 1'b1;
                    act_match = cmp_is_top ? ACT_NONE : ACT_SET;
                    act_top   = ACT_CLEAR;
                end
                default: begin
                    connected = 1'b0;
                end
            endcase
        end else begin
            case (out_mode_i)
                2'b01:   begin connected = 1'b1; act_match = ACT_TOGGLE; end
                2'b10:   begin connected = 1'b1; act_match = ACT_CLEAR;  end
                2'b11:   begin connected = 1'b1; act_match = ACT_SET;    end
                default: begin connected = 1'b0; end
            endcase
        end
    end

    // Pick the next state: the action at top wins, then the match action.
    always_comb begin
        if (at_top_i && (act_top != ACT_NONE)) begin
            wave_d = apply_act(act_top, wave_q);
        end else if (match) begin
            wave_d = apply_act(act_match, wave_q);
        end else begin
            wave_d = wave_q;
        end
    end

    // Channel state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave_q <= 1'b0;
        end else begin
            wave_q <= wave_d;
        end
    end

    assign drv_o = connected & dir_en_i;
    assign pin_o = drv_o & wave_q;

    // R4
    toggle_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i != WF_FAST && out_mode_i == 2'b01 && cnt_i == cmp_i)
        |=> (wave_q != $past(wave_q)));

    // R5
    set_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i != WF_FAST && out_mode_i[1] && cnt_i == cmp_i)
        |=> (wave_q == $past(out_mode_i[0])));

    // R7
    fast_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == WF_FAST && out_mode_i[1] && at_top_i)
        |=> (wave_q == !$past(out_mode_i[0])));

    // R8
    fast_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == WF_FAST && out_mode_i[1] && cnt_i == cmp_i && cmp_i != top_i)
        |=> (wave_q == $past(out_mode_i[0])));

    // R6
    idle_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode_i == 2'b00) |-> (!drv_o && !pin_o));

    // R11
    dir_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_en_i) |-> (!pin_o));

endmodule

// File: rtl/cmp_wavegen.sv
// Module: cmp_wavegen
// Top of the compare waveform generator: one counter shared by two
// compare channels, built through a generate loop. Channel index 0 is A.
// Assumes: all configuration inputs are synchronous to clk.
module cmp_wavegen
    import cwg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       wave_mode,
    input  logic [CNT_W-1:0] top_val,
    input  logic [1:0]       out_mode_a,
    input  logic [1:0]       out_mode_b,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic             dir_en_a,
    input  logic             dir_en_b,
    output logic             pin_a,
    output logic             pin_b,
    output logic             drv_a,
    output logic             drv_b
);
    localparam int NUM_CH = 2;

    wf_kind_e         kind;
    logic [CNT_W-1:0] cnt;
    logic             at_top;
    logic [1:0]       mode_arr [NUM_CH];
    logic [CNT_W-1:0] cmp_arr  [NUM_CH];
    logic             en_arr   [NUM_CH];
    logic             pin_arr  [NUM_CH];
    logic             drv_arr  [NUM_CH];

    // Classify the waveform code once for all channels.
    always_comb begin
        kind = classify_wave(wave_mode);
    end

    // Gather per-channel inputs into arrays for the generate loop.
    always_comb begin
        mode_arr[0] = out_mode_a;
        mode_arr[1] = out_mode_b;
        cmp_arr[0]  = cmp_a;
        cmp_arr[1]  = cmp_b;
        en_arr[0]   = dir_en_a;
        en_arr[1]   = dir_en_b;
    end

    cwg_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind_i   (kind),
        .top_i    (top_val),
        .cnt_o    (cnt),
        .at_top_o (at_top)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        cwg_channel #(
            .CNT_W     (CNT_W),
            .IS_CHAN_A (g == 0)
        ) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .kind_i      (kind),
            .wave_code_i (wave_mode),
            .out_mode_i  (mode_arr[g]),
            .cnt_i       (cnt),
            .cmp_i       (cmp_arr[g]),
            .top_i       (top_val),
            .at_top_i    (at_top),
            .dir_en_i    (en_arr[g]),
            .pin_o       (pin_arr[g]),
            .drv_o       (drv_arr[g])
        );
    end

    assign pin_a = pin_arr[0];
    assign pin_b = pin_arr[1];
    assign drv_a = drv_arr[0];
    assign drv_b = drv_arr[1];

    // R1
    reset_pin_chk: assert property (@(posedge clk)
        (!rst_n && !$isunknown($past(rst_n)) && !$past(rst_n)) |-> (!pin_a && !pin_b));

    // R10
    chan_b_toggle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == WF_FAST && out_mode_b == 2'b01) |-> !drv_b);

endmodule

// File: tb/cmp_wavegen_tb.sv
module cmp_wavegen_tb;
    localparam int W     = 8;
    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   wmode = 4'd0;
    logic [W-1:0] tp = '0;
    logic [1:0]   ma = 2'b00, mb = 2'b00;
    logic [W-1:0] ca = '0, cb = '0;
    logic         ea = 1'b0, eb = 1'b0;
    logic         pa, pb, da, db;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    cmp_wavegen #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wave_mode(wmode), .top_val(tp),
        .out_mode_a(ma), .out_mode_b(mb), .cmp_a(ca), .cmp_b(cb),
        .dir_en_a(ea), .dir_en_b(eb),
        .pin_a(pa), .pin_b(pb), .drv_a(da), .drv_b(db)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Hold reset for two edges, release at a falling edge.
    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_high(input int n, output int ha, output int hb);
        ha = 0; hb = 0;
        repeat (n) begin
            @(negedge clk);
            ha += int'(pa); hb += int'(pb);
        end
    endtask

    task automatic count_tr(input int n, output int ta, output int tb);
        logic la, lb;
        ta = 0; tb = 0; la = pa; lb = pb;
        repeat (n) begin
            @(negedge clk);
            if (pa != la) ta++;
            if (pb != lb) tb++;
            la = pa; lb = pb;
        end
    endtask

    // Expected high cycles per period for fast PWM, by R7/R8/R9.
    function automatic int exp_high(input int m, input int c, input int t);
        int hi;
        hi = (c >= t) ? t + 1 : c + 1;
        if (m == 3) hi = (c == t) ? 0 : ((c > t) ? 0 : t - c);
        return hi;
    endfunction

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int ha, hb, ta, tb;

        // R1: reset holds state at 0 even with a set-on-match channel at cmp 0
        wmode = 4'd4; tp = 8'd20; ma = 2'b11; ca = 8'd0; ea = 1'b1;
        @(negedge clk) rst_n = 1'b0;
        idle(3);
        chk(pa == 1'b0, "R1 pin during reset", pa, 0);
        chk(da == 1'b1, "R1 drive during reset", da, 1);

        // R4 timing: toggle appears after cmp+1 edges from release
        ma = 2'b01; ca = 8'd6;
        do_reset();
        chk(pa == 1'b0, "R1 pin after release", pa, 0);
        idle(6);
        chk(pa == 1'b0, "R4 before match edge", pa, 0);
        idle(1);
        chk(pa == 1'b1, "R4 at match edge", pa, 1);

        // R3/R4: CTC toggles once per top+1 cycles
        tp = 8'd10; ca = 8'd5; do_reset();
        count_tr(22, ta, tb);
        chk(ta == 2, "R3 CTC toggle count", ta, 2);

        // R2: Normal wraps at 255, one toggle per 256 cycles; code 1 behaves likewise
        wmode = 4'd0; do_reset();
        count_tr(512, ta, tb);
        chk(ta == 2, "R2 normal toggle count", ta, 2);
        wmode = 4'd1; do_reset();
        count_tr(512, ta, tb);
        chk(ta == 2, "R2 code1 toggle count", ta, 2);
        wmode = 4'd12; do_reset();
        count_tr(22, ta, tb);
        chk(ta == 2, "R2 code12 is CTC", ta, 2);

        // R5: set then clear in CTC
        wmode = 4'd4; tp = 8'd9; ma = 2'b11; ca = 8'd4; mb = 2'b11; cb = 8'd9; eb = 1'b1;
        do_reset(); idle(12);
        chk(pa == 1'b1, "R5 set on match A", pa, 1);
        chk(pb == 1'b1, "R5 set on match B", pb, 1);
        ma = 2'b10; idle(10);
        chk(pa == 1'b0, "R5 clear on match", pa, 0);
        chk(pb == 1'b1, "R5 other channel held", pb, 1);

        // R6: mode 00 disconnects in CTC and fast PWM
        ma = 2'b00; mb = 2'b00; idle(2);
        chk(da == 1'b0 && pa == 1'b0, "R6 A off CTC", da, 0);
        chk(db == 1'b0 && pb == 1'b0, "R6 B off CTC", db, 0);
        wmode = 4'd5; idle(2);
        chk(da == 1'b0 && db == 1'b0, "R6 off fast", da, 0);

        // R7/R8/R9: fast PWM duty sweep
        for (int code = 0; code < 2; code++) begin
            for (int ti = 0; ti < 3; ti++) begin
                for (int sw = 0; sw < 2; sw++) begin
                    for (int c = 0; c <= 13; c++) begin
                        int t;
                        t = (ti == 0) ? 3 : ((ti == 1) ? 7 : 12);
                        if (c <= t + 1) begin
                            wmode = (code == 0) ? 4'd5 : 4'd14;
                            tp = t[W-1:0]; ca = c[W-1:0]; cb = c[W-1:0];
                            ma = (sw == 0) ? 2'b10 : 2'b11;
                            mb = (sw == 0) ? 2'b11 : 2'b10;
                            do_reset();
                            idle(2 * (t + 1));
                            count_high(t + 1, ha, hb);
                            if (c == t) begin
                                chk(ha == exp_high(int'(ma), c, t), "R9 A cmp=top", ha, exp_high(int'(ma), c, t));
                                chk(hb == exp_high(int'(mb), c, t), "R9 B cmp=top", hb, exp_high(int'(mb), c, t));
                            end else begin
                                chk(ha == exp_high(int'(ma), c, t), "R7 A duty", ha, exp_high(int'(ma), c, t));
                                chk(hb == exp_high(int'(mb), c, t), "R8 B duty", hb, exp_high(int'(mb), c, t));
                            end
                        end
                    end
                end
            end
        end

        // R10: fast PWM mode 01
        tp = 8'd7; ca = 8'd3; cb = 8'd3; ma = 2'b01; mb = 2'b01;
        wmode = 4'd5; do_reset(); idle(3);
        chk(da == 1'b0, "R10 A off code5", da, 0);
        chk(db == 1'b0, "R10 B off code5", db, 0);
        wmode = 4'd14; do_reset(); idle(2);
        chk(da == 1'b1, "R10 A on code14", da, 1);
        chk(db == 1'b0, "R10 B off code14", db, 0);
        count_tr(16, ta, tb);
        chk(ta == 2, "R10 A toggles code14", ta, 2);
        wmode = 4'd15; do_reset(); count_tr(16, ta, tb);
        chk(ta == 2, "R10 A toggles code15", ta, 2);
        chk(db == 1'b0 && tb == 0, "R10 B off code15", tb, 0);

        // R11: direction enable gates the pin, state keeps running
        wmode = 4'd5; tp = 8'd7; ma = 2'b10; ca = 8'd7; ea = 1'b0;
        do_reset(); idle(20);
        chk(da == 1'b0 && pa == 1'b0, "R11 gated off", pa, 0);
        ea = 1'b1; #1;
        chk(da == 1'b1 && pa == 1'b1, "R11 state visible", pa, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule